// File: doc/BRIEF.md
# Reversible Carry-Save Adder Stage

This block is a purely combinational, bit-parallel adder stage. It is built from reversible cells that each have four inputs and four outputs. Each cell takes one bit from three operands and one ancilla bit, and produces four bits:

- the first two operand bits, passed through unchanged;
- the sum bit, in place of the third operand;
- the ancilla bit XORed with the majority of the three operand bits.

No carry moves between bit positions. The carry word therefore carries twice the weight of the sum word. Because no information is lost, the same cells can run backwards. With the direction input set, the stage takes a forward result and returns the third operand and the ancilla word that produced it.

A further operand can be absorbed with no carry propagation. The sum word and the carry word shifted left by one position become the two pass-through operands of a second pass, and the new operand goes in as the third. A single ordinary adder output, `chk_o`, folds the two result words into a binary total. It exists only so that a result can be checked.

Top module: `rev_csa_stage`

## Requirements
- R1: In both directions, bit i of `x_o` equals the XOR of bit i of `a_i`, `b_i` and `c_i`. With `inv`=0, the value of `a_i`+`b_i`+`c_i` equals `x_o` + 2·(`y_o` XOR `d_i`).
- R2: With `inv`=0, bit i of `y_o` equals bit i of `d_i` XOR the majority of bit i of `a_i`, `b_i` and `c_i`. In particular, with `c_i` and `d_i` zero, `y_o` equals `a_i` AND `b_i`.
- R3: `a_o` equals `a_i` and `b_o` equals `b_i` in both directions.
- R4: With `inv`=0, any permutation of the three operands across `a_i`, `b_i` and `c_i` yields the same `x_o` and `y_o`.
- R5: With `inv`=1, applying a forward result (sum on `c_i`, carry word on `d_i`) together with the unchanged `a_i` and `b_i` returns the original third operand on `x_o` and the original ancilla word on `y_o`, for any ancilla value.
- R6: `chk_o` is the (W+2)-bit value `x_o` + 2·`y_o`. With `inv`=0 and `d_i` zero, it equals `a_i`+`b_i`+`c_i`.
- R7: Take operands small enough that no bit is lost. Run a forward pass with a zero ancilla. Then run a second pass with its sum on `a_i`, its carry word shifted left by one on `b_i`, and a fourth operand on `c_i`. The second pass gives `chk_o` equal to the total of all four operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inv | input | 1 | 0 = forward evaluation, 1 = inverse evaluation |
| a_i | input | W | First pass-through operand |
| b_i | input | W | Second pass-through operand |
| c_i | input | W | Third operand (forward) or sum word (inverse) |
| d_i | input | W | Ancilla word (forward) or carry word (inverse) |
| a_o | output | W | Copy of `a_i` |
| b_o | output | W | Copy of `b_i` |
| x_o | output | W | Sum word (forward) or recovered third operand (inverse) |
| y_o | output | W | Ancilla XOR carry (forward) or recovered ancilla (inverse) |
| chk_o | output | W+2 | Binary total `x_o` + 2·`y_o` |

## Verification
Two functions can act on the same input word at once: the XOR-into-ancilla of the carry word, and the carry-save arithmetic.

The bench provokes this by applying nonzero ancilla words on random and tabled vectors. It checks both that the operand total still equals the sum word plus twice the unmasked carry word, and that `chk_o` reflects the masked word.

The inverse is judged on the same vectors. Each forward result is fed back with `inv` set, and the bench checks that both the third operand and the nonzero ancilla come back exactly.

// File: rtl/rev_csa_stage.sv
module rev_csa_stage #(
  parameter int W = 8
) (
  input  logic         inv,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic [W+1:0] chk_o
);
  localparam int CW = W + 2;

  logic [W-1:0] maj_in;

  assign a_o = a_i;
  assign b_o = b_i;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign x_o[i]    = a_i[i] ^ b_i[i] ^ c_i[i];
    // inverse: majority taken over the recovered operand bit
    assign maj_in[i] = inv ? x_o[i] : c_i[i];
    assign y_o[i]    = d_i[i] ^ ((a_i[i] & b_i[i]) | (a_i[i] & maj_in[i]) | (b_i[i] & maj_in[i]));
  end

  assign chk_o = {2'b00, x_o} + {1'b0, y_o, 1'b0};

  logic [CW-1:0] op_total, fwd_total, inv_left, inv_right;
  assign op_total  = {2'b00, a_i} + {2'b00, b_i} + {2'b00, c_i};
  assign fwd_total = {2'b00, x_o} + {1'b0, y_o ^ d_i, 1'b0};
  assign inv_left  = {2'b00, a_i} + {2'b00, b_i} + {2'b00, x_o};
  assign inv_right = {2'b00, c_i} + {1'b0, d_i ^ y_o, 1'b0};

  always_comb begin
    if (!inv) begin
      p_fwd_weight_r1: assert (op_total == fwd_total);
      if (d_i == '0)
        p_check_sum_r6: assert (chk_o == op_total);
      if (d_i == '0 && c_i == '0)
        p_half_carry_r2: assert (y_o == (a_i & b_i));
    end else begin
      p_inverse_restore_r5: assert (inv_left == inv_right);
    end
  end
endmodule

// File: tb/sim_rev_csa_stage.sv
module sim_rev_csa_stage;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic         inv;
  logic [W-1:0] a, b, c, d;
  logic [W-1:0] a_o, b_o, x_o, y_o;
  logic [W+1:0] chk_o;

  rev_csa_stage #(.W(W)) u0 (
    .inv(inv), .a_i(a), .b_i(b), .c_i(c), .d_i(d),
    .a_o(a_o), .b_o(b_o), .x_o(x_o), .y_o(y_o), .chk_o(chk_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // {a, b, c, d, expected x, expected y}
  localparam logic [47:0] TV [5] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF},
    {8'hF0, 8'hCC, 8'hAA, 8'h00, 8'h96, 8'hE8},
    {8'hF0, 8'hCC, 8'hAA, 8'hFF, 8'h96, 8'h17},
    {8'h01, 8'h02, 8'h03, 8'h5A, 8'h00, 8'h59}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic apply(input logic dir, input logic [W-1:0] ta, tb, tc, td);
    @(negedge clk);
    inv = dir; a = ta; b = tb; c = tc; d = td;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    finish_run();
  end

  initial begin
    inv = 0; a = '0; b = '0; c = '0; d = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    chk("R1 idle x", 32'(x_o), 0);
    chk("R2 idle y", 32'(y_o), 0);
    chk("R6 idle chk", 32'(chk_o), 0);

    for (int i = 0; i < 5; i++) begin
      apply(0, TV[i][47:40], TV[i][39:32], TV[i][31:24], TV[i][23:16]);
      chk("R1 table x", 32'(x_o), 32'(TV[i][15:8]));
      chk("R2 table y", 32'(y_o), 32'(TV[i][7:0]));
      chk("R3 table a", 32'(a_o), 32'(TV[i][47:40]));
      chk("R6 table chk", 32'(chk_o), 32'(TV[i][15:8]) + 2 * 32'(TV[i][7:0]));
      apply(1, TV[i][47:40], TV[i][39:32], TV[i][15:8], TV[i][7:0]);
      chk("R5 table c", 32'(x_o), 32'(TV[i][31:24]));
      chk("R5 table d", 32'(y_o), 32'(TV[i][23:16]));
    end

    // half-adder degenerate case
    apply(0, 8'h6C, 8'h3A, 8'h00, 8'h00);
    chk("R2 half carry", 32'(y_o), 32'h28);

    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] ra, rb, rc, rd, sx, sy;
      ra = W'($urandom); rb = W'($urandom); rc = W'($urandom); rd = W'($urandom);
      if (n % 4 == 0) rd = '0;
      apply(0, ra, rb, rc, rd);
      sx = x_o; sy = y_o;
      chk("R1 weight", 32'(ra) + 32'(rb) + 32'(rc), 32'(sx) + 2 * 32'(sy ^ rd));
      chk("R3 pass a", 32'(a_o), 32'(ra));
      chk("R3 pass b", 32'(b_o), 32'(rb));
      chk("R6 chk fold", 32'(chk_o), 32'(sx) + 2 * 32'(sy));
      if (rd == '0) chk("R6 chk total", 32'(chk_o), 32'(ra) + 32'(rb) + 32'(rc));
      apply(0, rc, ra, rb, rd);
      chk("R4 perm x", 32'(x_o), 32'(sx));
      chk("R4 perm y", 32'(y_o), 32'(sy));
      apply(1, ra, rb, sx, sy);
      chk("R5 recover c", 32'(x_o), 32'(rc));
      chk("R5 recover d", 32'(y_o), 32'(rd));
      chk("R3 inverse pass", 32'({a_o, b_o}), 32'({ra, rb}));
    end

    for (int n = 0; n < 100; n++) begin
      logic [W-1:0] ra, rb, rc, re, s1, k1;
      ra = W'($urandom % 64); rb = W'($urandom % 64);
      rc = W'($urandom % 64); re = W'($urandom % 64);
      apply(0, ra, rb, rc, '0);
      s1 = x_o; k1 = y_o;
      apply(0, s1, k1 << 1, re, '0);
      chk("R7 chained total", 32'(chk_o), 32'(ra) + 32'(rb) + 32'(rc) + 32'(re));
    end

    // boundary: all-ones operands, all-ones ancilla, inverse
    apply(1, 8'hFF, 8'hFF, 8'hFF, 8'h00);
    chk("R5 ones inverse c", 32'(x_o), 32'hFF);
    chk("R5 ones inverse d", 32'(y_o), 32'hFF);

    finish_run();
  end
endmodule